// File: doc/BRIEF.md
# Packet-Mode Two-Class Crossbar Scheduler

This block is the central scheduler of a combined input/output queued switch with N ports (16 by default). Every input keeps a virtual output queue per output for each of two traffic classes: class 0 carries admission-controlled QoS traffic and class 1 carries best-effort traffic. Each cycle the scheduler sees which of these queues hold a packet and the length in cells of the packet at the head of each one. From this it builds a one-to-one input-to-output matching that sets up the crossbar.

Matching is a single request-grant-accept round per cycle with round-robin pointers, in the style of iSLIP, but it works on whole packets. A matched pair stays connected until the packet's last cell has crossed. Ports that stay unmatched simply compete again in the next cycle. Class 0 always wins over class 1, both when an output grants and when an input accepts. Within a class, each queue hands over its head packet, so packets in a queue keep their order.

Every input runs a small state machine with two states. In `CT_IDLE` the input carries nothing. In `CT_XFER` it carries one packet and counts down the remaining cells. The transition `CT_IDLE -> CT_XFER` happens on an accepted match. The transition `CT_XFER -> CT_IDLE` happens after the last cell, unless a new match is accepted in that cycle, in which case the machine goes `CT_XFER -> CT_XFER` and the next packet starts at once. The buffer logic pops the head of the queue named by `link_out`/`link_vc` in the cycle where `link_head` is set.

Top module: `xs_pkt_sched`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, no input is connected (`link_act` all zero), whatever the requests are.
- R2: A packet whose queue is non-empty while both its input and its output are free and nothing contends starts one cycle later. In that cycle `link_act[i]` and `link_head[i]` are 1, `link_out` field i (bits i*PW upward) gives the output and `link_vc[i]` gives the class (0 = QoS, 1 = best effort). `link_head` is 1 only in the first cycle of a packet.
- R3: A connection stays active for exactly the head length in cells, taken from `head_len` bits ((vc*N+i)*N+o)*LW upward. A length of 0 counts as 1 cell.
- R4: While input i holds output o, `link_out`/`link_vc` of i stay the same, and no other input is matched to o until the cycle after i's last cell.
- R5: An input carries one packet at a time. The next packet on the same input may start in the cycle right after the last cell. After a one-cell packet there is always exactly one idle cycle.
- R6: When an output receives requests from both classes, it grants a class-0 request.
- R7: When an input receives grants of both classes, it accepts the class-0 grant.
- R8: Each output has a grant pointer per class. The pointer moves to one past the accepted input only when its grant is accepted, so contending inputs take turns.
- R9: Each input has an accept pointer per class. The pointer moves to one past the accepted output, so a waiting input serves its outputs in rotation.
- R10: No output is ever connected to two inputs in the same cycle.
- R11: Queue occupancy is given on `voq_qos`/`voq_be`, with bit i*N+o meaning that input i holds a packet for output o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| voq_qos | input | N*N | Class-0 queue non-empty flags, bit i*N+o |
| voq_be | input | N*N | Class-1 queue non-empty flags, bit i*N+o |
| head_len | input | 2*N*N*LW | Head-packet length in cells per queue, field ((vc*N+i)*N+o) |
| link_act | output | N | Input i is transferring a cell this cycle |
| link_head | output | N | First cell of a packet on input i; pop strobe |
| link_vc | output | N | Class of the packet on input i |
| link_out | output | N*PW | Output selected for input i, field i |

## Verification
Some behaviours are checked by the assertions in every cycle: the matching is one-to-one at the outputs, a new connection opens with a head cell, head cells never occur in two consecutive cycles on one input, and a connection's path and class stay stable until it ends. Other behaviours can only be shown by the bench scenarios: the exact length each connection is held, class precedence at grant and at accept, the rotation of the grant and accept pointers under contention, and the idle slot that follows a one-cell packet.

// File: rtl/xs_pkg.sv
package xs_pkg;

    // Traffic class carried on a connection
    typedef enum logic {
        VC_QOS = 1'b0,
        VC_BE  = 1'b1
    } vc_e;

    // Per-input connection tracker states
    typedef enum logic {
        CT_IDLE = 1'b0,
        CT_XFER = 1'b1
    } ct_state_e;

endpackage

// File: rtl/xs_rr_pick.sv
module xs_rr_pick #(
    parameter int N = 16,
    localparam int PW = $clog2(N)
) (
    input  logic [N-1:0]  req,
    input  logic [PW-1:0] ptr,
    output logic [N-1:0]  gnt,
    output logic          any
);
    localparam logic [PW:0] NV = (PW+1)'(N);

    logic [PW:0] pos;

    // first requester at or after ptr, wrapping
    always_comb begin
        gnt = '0;
        any = 1'b0;
        pos = '0;
        for (int k = 0; k < N; k++) begin
            pos = {1'b0, ptr} + (PW+1)'(k);
            if (pos >= NV) pos = pos - NV;
            if (!any && req[pos[PW-1:0]]) begin
                any = 1'b1;
                gnt[pos[PW-1:0]] = 1'b1;
            end
        end
    end
endmodule

// File: rtl/xs_conn_track.sv
module xs_conn_track
    import xs_pkg::*;
#(
    parameter int PW = 4,
    parameter int LW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [PW-1:0] ld_out,
    input  logic          ld_be,
    input  logic [LW-1:0] ld_len,
    output logic          act,
    output logic          head,
    output logic          avail,
    output logic [PW-1:0] out_idx,
    output logic          vc_be
);
    ct_state_e     st, st_nx;
    logic [LW-1:0] cnt;
    logic          head_q;

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            CT_IDLE: if (load) st_nx = CT_XFER;
            CT_XFER: begin
                if (load)                   st_nx = CT_XFER;
                else if (cnt == LW'(1))     st_nx = CT_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= CT_IDLE;
        else        st <= st_nx;
    end

    // cell counter and path registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            head_q  <= 1'b0;
            out_idx <= '0;
            vc_be   <= 1'b0;
        end else begin
            head_q <= load;
            if (load) begin
                cnt     <= (ld_len == '0) ? LW'(1) : ld_len;
                out_idx <= ld_out;
                vc_be   <= ld_be;
            end else if (st == CT_XFER) begin
                cnt <= cnt - LW'(1);
            end
        end
    end

    // outputs
    always_comb begin
        act   = (st == CT_XFER);
        head  = head_q;
        avail = (st == CT_IDLE) || (cnt == LW'(1) && !head_q);
    end
endmodule

// File: rtl/xs_pkt_sched.sv
module xs_pkt_sched #(
    parameter int N  = 16,
    parameter int LW = 6,
    localparam int PW = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N*N-1:0]    voq_qos,
    input  logic [N*N-1:0]    voq_be,
    input  logic [2*N*N*LW-1:0] head_len,
    output logic [N-1:0]      link_act,
    output logic [N-1:0]      link_head,
    output logic [N-1:0]      link_vc,
    output logic [N*PW-1:0]   link_out
);
    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] v);
        return (v == PW'(N-1)) ? '0 : v + PW'(1);
    endfunction

    logic [N-1:0]  in_avail, out_avail;
    logic [PW-1:0] cur_out [N];
    logic [N-1:0]  gnt_vec [N];   // per output, onehot over inputs
    logic [N-1:0]  gnt_be;        // per output, grant is class 1
    logic [N-1:0]  acc, acc_be;
    logic [PW-1:0] acc_out [N];
    logic [PW-1:0] gp_q [N], gp_b [N], ap_q [N], ap_b [N];

    // an output is free unless an input that is not releasing holds it
    always_comb begin
        out_avail = '1;
        for (int i = 0; i < N; i++)
            if (!in_avail[i]) out_avail[cur_out[i]] = 1'b0;
    end

    // grant stage, one pair of arbiters per output
    for (genvar o = 0; o < N; o++) begin : g_out
        logic [N-1:0] rq, rb, gq, gb;
        logic         aq, ab;
        always_comb begin
            for (int i = 0; i < N; i++) begin
                rq[i] = in_avail[i] & out_avail[o] & voq_qos[i*N+o];
                rb[i] = in_avail[i] & out_avail[o] & voq_be[i*N+o];
            end
        end
        xs_rr_pick #(.N(N)) u_gq (.req(rq), .ptr(gp_q[o]), .gnt(gq), .any(aq));
        xs_rr_pick #(.N(N)) u_gb (.req(rb), .ptr(gp_b[o]), .gnt(gb), .any(ab));
        assign gnt_vec[o] = aq ? gq : (ab ? gb : '0);
        assign gnt_be[o]  = !aq;
    end

    // accept stage and connection tracking, per input
    for (genvar i = 0; i < N; i++) begin : g_in
        logic [N-1:0]  cq, cb, aqv, abv;
        logic          aqa, aba;
        logic [PW-1:0] sel;
        logic [LW-1:0] len_sel;

        always_comb begin
            for (int o = 0; o < N; o++) begin
                cq[o] = gnt_vec[o][i] & !gnt_be[o];
                cb[o] = gnt_vec[o][i] &  gnt_be[o];
            end
        end
        xs_rr_pick #(.N(N)) u_aq (.req(cq), .ptr(ap_q[i]), .gnt(aqv), .any(aqa));
        xs_rr_pick #(.N(N)) u_ab (.req(cb), .ptr(ap_b[i]), .gnt(abv), .any(aba));

        always_comb begin
            sel = '0;
            for (int o = 0; o < N; o++)
                if (aqa ? aqv[o] : abv[o]) sel = PW'(o);
        end

        assign acc[i]     = aqa | aba;
        assign acc_be[i]  = !aqa;
        assign acc_out[i] = sel;
        assign len_sel    = head_len[((int'(acc_be[i])*N + i)*N + int'(sel))*LW +: LW];

        xs_conn_track #(.PW(PW), .LW(LW)) u_trk (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (acc[i]),
            .ld_out  (sel),
            .ld_be   (acc_be[i]),
            .ld_len  (len_sel),
            .act     (link_act[i]),
            .head    (link_head[i]),
            .avail   (in_avail[i]),
            .out_idx (cur_out[i]),
            .vc_be   (link_vc[i])
        );
        assign link_out[i*PW +: PW] = cur_out[i];
    end

    // round-robin pointers move only on an accepted grant
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < N; k++) begin
                gp_q[k] <= '0;
                gp_b[k] <= '0;
                ap_q[k] <= '0;
                ap_b[k] <= '0;
            end
        end else begin
            for (int i = 0; i < N; i++) begin
                if (acc[i]) begin
                    if (!acc_be[i]) begin
                        ap_q[i]          <= nxt(acc_out[i]);
                        gp_q[acc_out[i]] <= nxt(PW'(i));
                    end else begin
                        ap_b[i]          <= nxt(acc_out[i]);
                        gp_b[acc_out[i]] <= nxt(PW'(i));
                    end
                end
            end
        end
    end
endmodule

// File: rtl/xs_pkt_sched_chk.sv
module xs_pkt_sched_chk #(
    parameter int N  = 16,
    parameter int LW = 6,
    localparam int PW = $clog2(N)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [N-1:0]    link_act,
    input logic [N-1:0]    link_head,
    input logic [N-1:0]    link_vc,
    input logic [N*PW-1:0] link_out
);
    logic clash;

    always_comb begin
        clash = 1'b0;
        for (int a = 0; a < N; a++)
            for (int b = a + 1; b < N; b++)
                if (link_act[a] && link_act[b] &&
                    link_out[a*PW +: PW] == link_out[b*PW +: PW])
                    clash = 1'b1;
    end

    assert_one_to_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !clash);

    for (genvar i = 0; i < N; i++) begin : g_chk
        assert_open_with_head_R2: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(link_act[i]) |-> link_head[i]);

        assert_head_needs_link_R2: assert property (@(posedge clk) disable iff (!rst_n)
            link_head[i] |-> link_act[i]);

        assert_no_double_head_R5: assert property (@(posedge clk) disable iff (!rst_n)
            link_head[i] |=> !link_head[i]);

        assert_path_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (link_act[i] && !link_head[i]) |->
            ($past(link_act[i]) && $stable(link_out[i*PW +: PW]) && $stable(link_vc[i])));
    end
endmodule

bind xs_pkt_sched xs_pkt_sched_chk #(.N(N), .LW(LW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_act  (link_act),
    .link_head (link_head),
    .link_vc   (link_vc),
    .link_out  (link_out)
);

// File: tb/test_xs_pkt_sched.sv
module test_xs_pkt_sched;
    localparam int N  = 16;
    localparam int LW = 6;
    localparam int PW = $clog2(N);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [N*N-1:0]     voq_qos = '0;
    logic [N*N-1:0]     voq_be = '0;
    logic [2*N*N*LW-1:0] head_len = '0;
    logic [N-1:0]       link_act, link_head, link_vc;
    logic [N*PW-1:0]    link_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    int cnt_m [2][N][N];
    int len_m [2][N][N];

    always #4 clk = ~clk;   // 125 MHz

    xs_pkt_sched #(.N(N), .LW(LW)) i_xs_pkt_sched (
        .clk(clk), .rst_n(rst_n), .voq_qos(voq_qos), .voq_be(voq_be),
        .head_len(head_len), .link_act(link_act), .link_head(link_head),
        .link_vc(link_vc), .link_out(link_out)
    );

    // single-packet vectors: input, output, class, length
    localparam int NV = 6;
    localparam int TBL [NV][4] = '{
        '{0, 1, 0, 1}, '{3, 15, 1, 5}, '{12, 13, 0, 0},
        '{6, 2, 1, 63}, '{15, 14, 0, 7}, '{9, 7, 1, 3}
    };

    function automatic int lo(input int i);
        return int'(link_out[i*PW +: PW]);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int v = 0; v < 2; v++)
            for (int i = 0; i < N; i++)
                for (int o = 0; o < N; o++) begin
                    cnt_m[v][i][o] = 0;
                    len_m[v][i][o] = 0;
                end
    endtask

    task automatic apply();
        for (int v = 0; v < 2; v++)
            for (int i = 0; i < N; i++)
                for (int o = 0; o < N; o++) begin
                    if (v == 0) voq_qos[i*N+o] = (cnt_m[v][i][o] > 0);
                    else        voq_be[i*N+o]  = (cnt_m[v][i][o] > 0);
                    head_len[((v*N+i)*N+o)*LW +: LW] = LW'(len_m[v][i][o]);
                end
    endtask

    // advance to the next sampling point, pop heads, check R10 each cycle
    task automatic tick();
        bit clash;
        @(negedge clk);
        clash = 1'b0;
        for (int a = 0; a < N; a++)
            for (int b = a + 1; b < N; b++)
                if (link_act[a] && link_act[b] && lo(a) == lo(b)) clash = 1'b1;
        chk(!clash, "R10 one-to-one", int'(clash), 0);
        for (int i = 0; i < N; i++)
            if (link_head[i] && cnt_m[link_vc[i]][i][lo(i)] > 0)
                cnt_m[link_vc[i]][i][lo(i)]--;
        apply();
    endtask

    task automatic load(input int i, input int o, input int v, input int len, input int n);
        cnt_m[v][i][o] = n;
        len_m[v][i][o] = len;
    endtask

    task automatic expect_head(input int i, input int o, input int v, input string req);
        chk(link_head[i] && link_act[i], req, int'(link_head[i]), 1);
        chk(lo(i) == o && int'(link_vc[i]) == v, req, lo(i)*2 + int'(link_vc[i]), o*2 + v);
    endtask

    task automatic run_single(input int i, input int o, input int v, input int len);
        int  eff;
        bit  held;
        eff = (len == 0) ? 1 : len;
        load(i, o, v, len, 1);
        apply();
        tick();
        expect_head(i, o, v, "R2 single start");
        chk($countones(link_act) == 1, "R2 only one link", $countones(link_act), 1);
        held = 1'b1;
        for (int c = 1; c < eff; c++) begin
            tick();
            if (!link_act[i] || link_head[i]) held = 1'b0;
        end
        chk(held, "R3 held for length", int'(held), 1);
        tick();
        chk(!link_act[i], "R3 released after length", int'(link_act[i]), 0);
    endtask

    initial begin
        clear_model();
        // R1: requests present during reset must not connect
        load(4, 5, 0, 3, 1);
        apply();
        repeat (3) @(negedge clk);
        chk(link_act == '0, "R1 idle in reset", int'(link_act), 0);
        clear_model();
        apply();
        @(negedge clk);
        rst_n = 1'b1;
        tick();
        chk(link_act == '0 && link_head == '0, "R1 idle after reset", int'(link_act), 0);

        // table walk: R2, R3 (R11 encodings)
        for (int t = 0; t < NV; t++) begin
            run_single(TBL[t][0], TBL[t][1], TBL[t][2], TBL[t][3]);
            tick();
        end

        // R4, R8: inputs 2 and 5 contend for output 3 (class 1, 2 cells, 2 packets each)
        load(2, 3, 1, 2, 2);
        load(5, 3, 1, 2, 2);
        apply();
        tick();
        expect_head(2, 3, 1, "R8 first grant input 2");
        chk(!link_act[5], "R4 output locked", int'(link_act[5]), 0);
        tick();
        chk(!link_act[5], "R4 locked to last cell", int'(link_act[5]), 0);
        tick();
        expect_head(5, 3, 1, "R8 turn to input 5");
        tick(); tick();
        expect_head(2, 3, 1, "R8 back to input 2");
        tick(); tick();
        expect_head(5, 3, 1, "R8 then input 5");
        tick(); tick();
        chk(link_act == '0, "R4 all released", int'(link_act), 0);

        // R6: output 4 sees class 1 from input 1 and class 0 from input 6
        load(1, 4, 1, 3, 1);
        load(6, 4, 0, 3, 1);
        apply();
        tick();
        expect_head(6, 4, 0, "R6 class 0 granted");
        chk(!link_act[1], "R6 class 1 waits", int'(link_act[1]), 0);
        tick(); tick(); tick();
        expect_head(1, 4, 1, "R6 class 1 after");
        tick(); tick(); tick();

        // R7, R5: input 7 granted class 1 by output 8 and class 0 by output 9
        load(7, 8, 1, 2, 1);
        load(7, 9, 0, 2, 1);
        apply();
        tick();
        expect_head(7, 9, 0, "R7 class 0 accepted");
        tick();
        tick();
        expect_head(7, 8, 1, "R5 back-to-back start");
        tick(); tick();

        // R9, R5: input 10 holds class-1 one-cell packets for outputs 0 (x2) and 11
        load(10, 0, 1, 1, 2);
        load(10, 11, 1, 1, 1);
        apply();
        tick();
        expect_head(10, 0, 1, "R9 first output 0");
        tick();
        chk(!link_act[10], "R5 idle after one-cell packet", int'(link_act[10]), 0);
        tick();
        expect_head(10, 11, 1, "R9 rotates to output 11");
        tick(); tick();
        expect_head(10, 0, 1, "R9 wraps to output 0");
        tick(); tick();
        chk(link_act == '0, "R9 drained", int'(link_act), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule